// File: doc/BRIEF.md
# Periodic Interval Tick Timer

This block produces a steady time base for an operating system tick. The system clock runs through a fixed divide-by-16 prescaler. Each prescaled step advances a 20-bit counter. When the counter equals a programmable interval, it returns to zero and one tick is recorded. For a 1 ms period, the interval is the system clock frequency divided by 16000, minus one.

Every tick adds one to a 12-bit accumulator of elapsed periods. If software services the block late, it can still tell how many periods have passed. Software reads the counter and the accumulator together through one of two words. The value word hands the accumulated ticks over and clears them, which also acknowledges the interrupt. The image word returns the same fields and changes nothing.

A mode word holds the interval, a run enable and an interrupt enable. The interrupt output is raised while ticks are pending and both enables are set.

Top module: `ppt_tick_timer`

## Requirements
- R1: After reset, every readable word returns zero and `irq` is low.
- R2: While running, the counter advances by one once every 16 clock cycles. It holds its value at all other times.
- R3: When the counter equals the interval at an advance, it returns to zero instead of incrementing. A tick therefore occurs every 16 × (interval + 1) clock cycles.
- R4: Each tick adds one to the tick count. The value and image words carry the counter in bits 19:0 and the tick count in bits 31:20.
- R5: Reading the value word (word address 2) returns the current fields and clears the tick count on that clock edge. Reading the image word (word address 3) returns the same fields and clears nothing.
- R6: If a tick occurs on the same edge as a value-word read, the tick count after the read is one.
- R7: The tick count saturates at 4095 rather than wrapping.
- R8: Bit 0 of the status word (word address 1) is set exactly when the tick count is nonzero. All other status bits read as zero.
- R9: `irq` is high exactly when the tick count is nonzero, the interrupt enable is set and the run enable is set.
- R10: After the run enable is cleared, counting continues until the next return to zero, and that return still records a tick. The counter and prescaler then stay at zero.
- R11: The mode word (word address 0) holds the interval in bits 19:0, run enable in bit 24 and interrupt enable in bit 25, and reads back with all other bits zero. Writes to any other word address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 mode, 1 status, 2 value, 3 image |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| irq | output | 1 | Tick interrupt request |

## Verification
The assertions assume that each access strobe lasts a single cycle. They also assume the interval is never changed to a value below the counter's current value while the block is running. Otherwise the counter would have to run all the way to its 20-bit limit before it returned to zero.

The stimulus holds every access for exactly one clock and deasserts the strobe between accesses. It changes the interval only at points where the new interval is no smaller than the running counter. It places one value read exactly on a tick edge, so the read and the tick collide on the same cycle.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
   localparam int BUS_W   = 32;
   localparam int RUN_POS = 24;
   localparam int IEN_POS = 25;

   typedef enum logic [1:0] {
      WA_MODE  = 2'd0,
      WA_STAT  = 2'd1,
      WA_VALUE = 2'd2,
      WA_IMAGE = 2'd3
   } word_addr_e;
endpackage

// File: rtl/ppt_prescale.sv
module ppt_prescale #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic strobe,
   output logic busy
);
   initial begin
      assert (DIV >= 1) else $error("ppt_prescale: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_direct
         assign strobe = run;
         assign busy   = 1'b0;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pre_q <= '0;
            else if (!run)          pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end

         assign strobe = run && (pre_q == LAST);
         assign busy   = (pre_q != '0);

         assert_stride_R2: assert property (@(posedge clk) disable iff (!rst_n)
            strobe |=> !strobe);
      end
   endgenerate
endmodule

// File: rtl/ppt_count.sv
module ppt_count #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] interval,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   assign wrap = step && (cnt == interval);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));
endmodule

// File: rtl/ppt_accum.sv
module ppt_accum #(
   parameter int W   = 12,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;
   logic [W-1:0] base;
   logic [W-1:0] nxt;

   assign base = clr ? '0 : count;

   generate
      if (SAT) begin : g_sat
         assign nxt = (tick && base != TOP) ? base + 1'b1 : base;

         assert_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (count >= $past(count)));
      end else begin : g_wrap
         assign nxt = tick ? base + 1'b1 : base;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end

   assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tick) |=> (count == '0));
   assert_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && tick) |=> (count == W'(1)));
endmodule

// File: rtl/ppt_tick_timer.sv
module ppt_tick_timer
   import ppt_pkg::*;
#(
   parameter int CNT_W    = 20,
   parameter int TICK_W   = 12,
   parameter int DIV      = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq
);
   initial begin
      assert (CNT_W + TICK_W == BUS_W) else $error("ppt_tick_timer: fields must fill the bus word");
      assert (CNT_W <= RUN_POS) else $error("ppt_tick_timer: interval overlaps enable bits");
   end

   logic [CNT_W-1:0]  int_q;
   logic              run_q;
   logic              ien_q;
   logic [CNT_W-1:0]  cnt;
   logic [TICK_W-1:0] ticks;
   logic              step, wrap, pre_busy, active, pending;
   logic              wr_mode, rd_value;

   assign wr_mode  = bus_sel && bus_wr  && (bus_addr == WA_MODE);
   assign rd_value = bus_sel && !bus_wr && (bus_addr == WA_VALUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q <= '0;
         run_q <= 1'b0;
         ien_q <= 1'b0;
      end else if (wr_mode) begin
         int_q <= bus_wdata[CNT_W-1:0];
         run_q <= bus_wdata[RUN_POS];
         ien_q <= bus_wdata[IEN_POS];
      end
   end

   // keep running until the period in progress has closed
   assign active = run_q || (cnt != '0) || pre_busy;

   ppt_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(active), .strobe(step), .busy(pre_busy)
   );

   ppt_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .interval(int_q), .cnt(cnt), .wrap(wrap)
   );

   ppt_accum #(.W(TICK_W), .SAT(SATURATE)) u_acc (
      .clk(clk), .rst_n(rst_n), .tick(wrap), .clr(rd_value), .count(ticks)
   );

   assign pending = (ticks != '0);
   assign irq     = pending && ien_q && run_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         WA_MODE: begin
            bus_rdata[CNT_W-1:0] = int_q;
            bus_rdata[RUN_POS]   = run_q;
            bus_rdata[IEN_POS]   = ien_q;
         end
         WA_STAT:  bus_rdata[0] = pending;
         default:  bus_rdata    = {ticks, cnt};
      endcase
   end

   assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ticks != '0));
   assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && cnt == '0 && !pre_busy) |=> (cnt == '0));
endmodule

// File: tb/tb_ppt_tick_timer.sv
module tb_ppt_tick_timer;
   localparam int DIV  = 16;
   localparam int TMAX = 4095;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ppt_tick_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // reference model of the requirements, advanced once per clock edge
   logic [19:0] m_int = '0, m_cnt = '0;
   logic        m_run = 0, m_ien = 0;
   int          m_pre = 0;
   int          m_tk  = 0;

   function automatic bit m_active();
      return m_run || (m_cnt != 0) || (m_pre != 0);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit act, stb, tk;
         int base;
         act = m_active();
         stb = act && (m_pre == DIV - 1);
         tk  = stb && (m_cnt == m_int);
         m_pre = act ? (m_pre + 1) % DIV : 0;
         if (tk) m_cnt = '0;
         else if (stb) m_cnt = m_cnt + 20'd1;
         base = (bus_sel && !bus_wr && bus_addr == 2'd2) ? 0 : m_tk;
         if (tk && base < TMAX) base = base + 1;
         m_tk = base;
         if (bus_sel && bus_wr && bus_addr == 2'd0) begin
            m_int = bus_wdata[19:0];
            m_run = bus_wdata[24];
            m_ien = bus_wdata[25];
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [1:0] a);
      case (a)
         2'd0:    return {6'd0, m_ien, m_run, 4'd0, m_int};
         2'd1:    return {31'd0, m_tk != 0};
         default: return {m_tk[11:0], m_cnt};
      endcase
   endfunction

   // scoreboard
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always @(negedge clk) begin
      #2;
      if (bus_sel && !bus_wr) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s read with no expectation: actual=%h expected=none", "scoreboard", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               fails++;
               $display("FAIL %s addr=%0d actual=%h expected=%h", t, bus_addr, bus_rdata, e);
            end
         end
      end
   end

   // driver tasks: called right after a falling edge
   task automatic rd(input logic [1:0] a, input string t);
      exp_q.push_back(m_read(a));
      tag_q.push_back(t);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (irq !== e) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
      end
   endtask

   function automatic logic [31:0] mode(input int iv, input bit run, input bit ien);
      return {6'd0, ien, run, 4'd0, 20'(iv)};
   endfunction

   initial begin
      #1_900_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd3, "R1"); rd(2'd2, "R1");
      chk_irq(1'b0, "R1");
      // R11 mode readback, foreign writes ignored
      wr(2'd0, mode(2, 1, 0));
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd0, "R11");
      // R2 counter stepping
      idle(20); rd(2'd3, "R2");
      idle(7);  rd(2'd3, "R2");
      // R3/R4 wrap and tick count
      idle(40); rd(2'd3, "R3_R4");
      rd(2'd1, "R8");
      chk_irq(1'b0, "R9");
      wr(2'd0, mode(2, 1, 1));
      chk_irq(1'b1, "R9");
      idle(50); rd(2'd3, "R4");
      // R5 destructive vs image read
      rd(2'd2, "R5");
      rd(2'd3, "R5");
      rd(2'd1, "R8");
      chk_irq(1'b0, "R9");
      // R6 tick on the same edge as a value read
      while (!(m_active() && m_pre == DIV - 1 && m_cnt == m_int)) @(negedge clk);
      rd(2'd2, "R6");
      rd(2'd3, "R6");
      chk_irq(1'b1, "R6_R9");
      // R10 stop after finishing the period
      wr(2'd0, mode(3, 1, 1));
      idle(30);
      chk_irq(1'b1, "R9");
      wr(2'd0, mode(3, 0, 1));
      chk_irq(1'b0, "R9");
      rd(2'd3, "R10");
      idle(200); rd(2'd3, "R10");
      idle(40);  rd(2'd3, "R10");
      rd(2'd1, "R8");
      // R7 saturation with the shortest interval
      wr(2'd0, mode(0, 1, 0));
      rd(2'd2, "R5");
      idle(4096 * DIV + 200);
      rd(2'd3, "R7");
      idle(100); rd(2'd3, "R7");
      rd(2'd2, "R7");
      rd(2'd3, "R5");
      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule